// File: doc/BRIEF.md
# Receive Signaling Conditioning Unit

This unit sits on the receive side of a multi-link DS1/E1 framer. The framer presents robbed-bit signaling values one time slot at a time. The unit stores each 4-bit ABCD value in a per-link, per-slot register. A scan pointer then walks the active links in turn and drives the stored signaling toward the system side, one time slot per clock.

Two conditioning features act on this path. The first is an automatic freeze: when it is enabled, a framing-bit error on a link stops updates to that link's signaling registers. Updates come back only after a complete multiframe has passed without another framing-bit error. The second is alarm forcing: when the global alarm enable is set, time slots on a link whose handling group has lost alignment are replaced with all-ones signaling at the system output. This applies only to links configured for byte-synchronous mapping with handling groups.

The framer supplies framing-bit error strobes, multiframe boundary strobes and alignment flags. A small register interface holds the link count, the two global enables and the per-link mapping options.

Top module: `rsc_unit`

## Requirements
- R1: The link count sits in bits 14:10 of the global register (address 0) and resets to 28. A count of 0 services no link, so `sys_valid` stays low. A count above 28 services 28 links.
- R2: A signaling sample (`sig_valid`) for an active, unfrozen link is stored for that link and slot. A sample with slot index 24 or more is ignored.
- R3: The scan visits links 0 to count-1 for one slot, then moves to the next slot (23 wraps to 0), one entry per clock. Each entry appears on `sys_*` on the clock after the pointer reaches it, carrying the stored ABCD value.
- R4: A link at or above the link count is neither scanned nor written. Samples for such a link are dropped.
- R5: The freeze enable is global bit 1. While it is set, a framing-bit error on a link blocks that link's write in the same cycle, and later writes stay blocked. The first multiframe boundary after the last error starts a clean multiframe. The next boundary, if no error has arrived in between, re-opens writes from the following cycle. An error in any frozen state restarts this sequence.
- R6: While the freeze enable is 0, framing-bit errors have no effect on writes.
- R7: When global bit 15 is 1, and the link's per-link register (address 32+link) has bit 1 (byte-synchronous) and bit 0 (handling groups) both set, and `hg_misalign` for that link is high, the scanned output is 4'hF. Otherwise the stored value passes unchanged.
- R8: Reserved bits read as 0: global bits 9:2 and bit 0, per-link bits 15:2, and any unmapped address. Both enables and all per-link bits reset to 0.
- R9: After reset all stored signaling is 0 and `sys_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address (0 global, 32+n link n) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr (combinational) |
| sig_valid | input | 1 | Signaling sample present |
| sig_link | input | 5 | Link of the sample |
| sig_slot | input | 5 | Time slot of the sample |
| sig_data | input | 4 | ABCD value |
| frm_bit_err | input | 28 | Per-link framing-bit error strobe |
| mf_start | input | 28 | Per-link multiframe boundary strobe |
| hg_misalign | input | 28 | Per-link handling group out of alignment |
| sys_valid | output | 1 | System output entry valid |
| sys_link | output | 5 | Link of the output entry |
| sys_slot | output | 5 | Slot of the output entry |
| sys_sig | output | 4 | Conditioned ABCD value |

## Verification
Register writes and signaling samples take effect at the clock edge where they are presented. A stored value or a changed enable shows up on `sys_*` the first time the scan reaches that entry after the edge, and the entry leaves the output register one clock after the pointer reaches it. Register readback is combinational, so it is checked within the same cycle as the address. The bench model advances its own pointer, storage and freeze states at every rising edge, using the values from before that edge. The bench compares the model against the outputs at every falling edge. Between stimuli it waits at least one full scan, so that every blocked or accepted write becomes visible before the next one.

// File: rtl/rsc_pkg.sv
// Shared types for the receive signaling conditioning unit.
// Assumes: nothing beyond IEEE 1800-2017.
package rsc_pkg;
    // Per-link freeze state: open, waiting for a boundary, clean multiframe in progress.
    typedef enum logic [1:0] {
        FZ_OPEN  = 2'd0,
        FZ_WAIT  = 2'd1,
        FZ_CLEAN = 2'd2
    } frz_state_t;

    localparam int AIS_BIT  = 15;
    localparam int CNT_LSB  = 10;
    localparam int FRZ_BIT  = 1;
    localparam int BSYNC_BIT = 1;
    localparam int HGRP_BIT  = 0;
endpackage

// File: rtl/rsc_cfg_regs.sv
// Configuration registers: global word at address 0, one word per link at 32+link.
// Produces the effective link count (0 stays 0, above NLINK clamps to NLINK).
// Assumes: AW-1 selects the per-link bank and the lower bits name the link.
module rsc_cfg_regs
    import rsc_pkg::*;
#(
    parameter int NLINK = 28,
    parameter int CW    = 5,
    parameter int AW    = 6,
    parameter int DW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    output logic             ais_en,
    output logic             frz_en,
    output logic [CW-1:0]    cnt_eff,
    output logic [NLINK-1:0] bsync_en,
    output logic [NLINK-1:0] hgrp_en
);
    localparam logic [CW-1:0] CNT_RST = CW'(NLINK);

    logic [CW-1:0]   link_cnt;
    logic [AW-2:0]   sel_link;
    logic            glob_hit;
    logic            link_hit;

    assign sel_link = cfg_addr[AW-2:0];
    assign glob_hit = (cfg_addr == '0);
    assign link_hit = cfg_addr[AW-1] && (32'(sel_link) < NLINK);
    assign cnt_eff  = (32'(link_cnt) > NLINK) ? CNT_RST : link_cnt;

    // Global word: alarm enable, link count, freeze enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ais_en   <= 1'b0;
            frz_en   <= 1'b0;
            link_cnt <= CNT_RST;
        end else if (cfg_we && glob_hit) begin
            ais_en   <= cfg_wdata[AIS_BIT];
            frz_en   <= cfg_wdata[FRZ_BIT];
            link_cnt <= cfg_wdata[CNT_LSB +: CW];
        end
    end

    // Per-link words: byte-synchronous mapping and handling-group enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsync_en <= '0;
            hgrp_en  <= '0;
        end else if (cfg_we && link_hit) begin
            bsync_en[sel_link] <= cfg_wdata[BSYNC_BIT];
            hgrp_en[sel_link]  <= cfg_wdata[HGRP_BIT];
        end
    end

    // Readback; reserved and unmapped bits return 0.
    always_comb begin
        cfg_rdata = '0;
        if (glob_hit) begin
            cfg_rdata[AIS_BIT]         = ais_en;
            cfg_rdata[CNT_LSB +: CW]   = link_cnt;
            cfg_rdata[FRZ_BIT]         = frz_en;
        end else if (link_hit) begin
            cfg_rdata[BSYNC_BIT] = bsync_en[sel_link];
            cfg_rdata[HGRP_BIT]  = hgrp_en[sel_link];
        end
    end
endmodule

// File: rtl/rsc_freeze_ctrl.sv
// Per-link freeze tracker. An error freezes the link; a boundary starts a clean
// multiframe; a second boundary with no error in between reopens updates.
// Assumes: error and boundary strobes are single-cycle and the error wins a tie.
module rsc_freeze_ctrl
    import rsc_pkg::*;
#(
    parameter int NLINK = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frz_en,
    input  logic [NLINK-1:0] frm_bit_err,
    input  logic [NLINK-1:0] mf_start,
    output logic [NLINK-1:0] hold
);
    for (genvar k = 0; k < NLINK; k++) begin : g_link
        frz_state_t st;

        // Advance this link's freeze state.
        always_ff @(posedge clk) begin
            if (!rst_n || !frz_en) begin
                st <= FZ_OPEN;
            end else if (frm_bit_err[k]) begin
                st <= FZ_WAIT;
            end else begin
                case (st)
                    FZ_WAIT:  if (mf_start[k]) st <= FZ_CLEAN;
                    FZ_CLEAN: if (mf_start[k]) st <= FZ_OPEN;
                    default:  st <= st;
                endcase
            end
        end

        assign hold[k] = (st != FZ_OPEN);
    end
endmodule

// File: rtl/rsc_sig_store.sv
// Signaling storage, one ABCD entry per link and slot, with gated write port
// and combinational read port for the scanner.
// Assumes: read address always names an existing entry.
module rsc_sig_store #(
    parameter int NLINK = 28,
    parameter int NSLOT = 24,
    parameter int SW    = 4,
    parameter int LW    = 5,
    parameter int SLW   = 5,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_valid,
    input  logic [LW-1:0]    sig_link,
    input  logic [SLW-1:0]   sig_slot,
    input  logic [SW-1:0]    sig_data,
    input  logic [CW-1:0]    cnt_eff,
    input  logic             frz_en,
    input  logic [NLINK-1:0] frm_bit_err,
    input  logic [NLINK-1:0] hold,
    input  logic [LW-1:0]    rd_link,
    input  logic [SLW-1:0]   rd_slot,
    output logic [SW-1:0]    rd_data
);
    localparam int DEPTH = NLINK * NSLOT;
    localparam int IW    = $clog2(DEPTH);

    logic [SW-1:0] mem [DEPTH];
    logic          in_range;
    logic          wr_ok;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    assign in_range = (32'(sig_link) < 32'(cnt_eff)) && (32'(sig_slot) < NSLOT);
    assign wr_ok    = sig_valid && in_range && !hold[sig_link]
                      && !(frz_en && frm_bit_err[sig_link]);
    assign wr_idx   = IW'(32'(sig_link) * NSLOT + 32'(sig_slot));
    assign rd_idx   = IW'(32'(rd_link) * NSLOT + 32'(rd_slot));
    assign rd_data  = mem[rd_idx];

    // Clear all entries on reset, otherwise store an accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_ok) begin
            mem[wr_idx] <= sig_data;
        end
    end
endmodule

// File: rtl/rsc_scan.sv
// Round-robin scanner: link index runs fastest, slot advances on link wrap.
// Registers one conditioned entry per clock toward the system side.
// Assumes: cnt_eff never exceeds NLINK.
module rsc_scan #(
    parameter int NLINK = 28,
    parameter int NSLOT = 24,
    parameter int SW    = 4,
    parameter int LW    = 5,
    parameter int SLW   = 5,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CW-1:0]    cnt_eff,
    input  logic             ais_en,
    input  logic [NLINK-1:0] bsync_en,
    input  logic [NLINK-1:0] hgrp_en,
    input  logic [NLINK-1:0] hg_misalign,
    input  logic [SW-1:0]    rd_data,
    output logic [LW-1:0]    ptr_link,
    output logic [SLW-1:0]   ptr_slot,
    output logic             scan_vld,
    output logic             sys_valid,
    output logic [LW-1:0]    sys_link,
    output logic [SLW-1:0]   sys_slot,
    output logic [SW-1:0]    sys_sig
);
    localparam logic [SLW-1:0] SLOT_LAST = SLW'(NSLOT - 1);

    logic [LW-1:0]  nxt_link;
    logic [SLW-1:0] nxt_slot;
    logic           ais_hit;

    assign scan_vld = (32'(ptr_link) < 32'(cnt_eff));
    assign ais_hit  = ais_en && bsync_en[ptr_link] && hgrp_en[ptr_link] && hg_misalign[ptr_link];

    // Next pointer: restart at link 0 when out of range, step slot on wrap.
    always_comb begin
        nxt_link = ptr_link;
        nxt_slot = ptr_slot;
        if (!scan_vld) begin
            nxt_link = '0;
        end else if (32'(ptr_link) == 32'(cnt_eff) - 1) begin
            nxt_link = '0;
            nxt_slot = (ptr_slot == SLOT_LAST) ? '0 : ptr_slot + 1'b1;
        end else begin
            nxt_link = ptr_link + 1'b1;
        end
    end

    // Pointer and registered output stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_link  <= '0;
            ptr_slot  <= '0;
            sys_valid <= 1'b0;
            sys_link  <= '0;
            sys_slot  <= '0;
            sys_sig   <= '0;
        end else begin
            ptr_link  <= nxt_link;
            ptr_slot  <= nxt_slot;
            sys_valid <= scan_vld;
            sys_link  <= ptr_link;
            sys_slot  <= ptr_slot;
            sys_sig   <= !scan_vld ? '0 : (ais_hit ? '1 : rd_data);
        end
    end
endmodule

// File: rtl/rsc_unit.sv
// Receive signaling conditioning unit top: configuration, freeze tracking,
// signaling storage and the round-robin system-side scanner.
// Assumes: framer strobes are synchronous to clk.
module rsc_unit #(
    parameter int NLINK = 28,
    parameter int NSLOT = 24,
    parameter int SW    = 4,
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int LW    = $clog2(NLINK),
    parameter int SLW   = $clog2(NSLOT),
    parameter int CW    = $clog2(NLINK + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic             sig_valid,
    input  logic [LW-1:0]    sig_link,
    input  logic [SLW-1:0]   sig_slot,
    input  logic [SW-1:0]    sig_data,
    input  logic [NLINK-1:0] frm_bit_err,
    input  logic [NLINK-1:0] mf_start,
    input  logic [NLINK-1:0] hg_misalign,
    output logic             sys_valid,
    output logic [LW-1:0]    sys_link,
    output logic [SLW-1:0]   sys_slot,
    output logic [SW-1:0]    sys_sig
);
    logic             ais_en;
    logic             frz_en;
    logic [CW-1:0]    cnt_eff;
    logic [NLINK-1:0] bsync_en;
    logic [NLINK-1:0] hgrp_en;
    logic [NLINK-1:0] hold;
    logic [LW-1:0]    ptr_link;
    logic [SLW-1:0]   ptr_slot;
    logic [SW-1:0]    rd_data;
    logic             scan_vld;

    rsc_cfg_regs #(.NLINK(NLINK), .CW(CW), .AW(AW), .DW(DW)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ais_en(ais_en),
        .frz_en(frz_en), .cnt_eff(cnt_eff), .bsync_en(bsync_en), .hgrp_en(hgrp_en)
    );

    rsc_freeze_ctrl #(.NLINK(NLINK)) frz_i (
        .clk(clk), .rst_n(rst_n), .frz_en(frz_en), .frm_bit_err(frm_bit_err),
        .mf_start(mf_start), .hold(hold)
    );

    rsc_sig_store #(.NLINK(NLINK), .NSLOT(NSLOT), .SW(SW), .LW(LW), .SLW(SLW), .CW(CW)) store_i (
        .clk(clk), .rst_n(rst_n), .sig_valid(sig_valid), .sig_link(sig_link),
        .sig_slot(sig_slot), .sig_data(sig_data), .cnt_eff(cnt_eff), .frz_en(frz_en),
        .frm_bit_err(frm_bit_err), .hold(hold), .rd_link(ptr_link), .rd_slot(ptr_slot),
        .rd_data(rd_data)
    );

    rsc_scan #(.NLINK(NLINK), .NSLOT(NSLOT), .SW(SW), .LW(LW), .SLW(SLW), .CW(CW)) scan_i (
        .clk(clk), .rst_n(rst_n), .cnt_eff(cnt_eff), .ais_en(ais_en),
        .bsync_en(bsync_en), .hgrp_en(hgrp_en), .hg_misalign(hg_misalign),
        .rd_data(rd_data), .ptr_link(ptr_link), .ptr_slot(ptr_slot),
        .scan_vld(scan_vld), .sys_valid(sys_valid), .sys_link(sys_link),
        .sys_slot(sys_slot), .sys_sig(sys_sig)
    );
endmodule

// File: rtl/rsc_unit_chk.sv
// Property checker for rsc_unit, attached through bind below.
// Assumes: sampled on the rising edge, disabled while reset is asserted.
module rsc_unit_chk #(
    parameter int NLINK = 28,
    parameter int NSLOT = 24,
    parameter int SW    = 4,
    parameter int AW    = 6,
    parameter int DW    = 16,
    parameter int LW    = 5,
    parameter int SLW   = 5,
    parameter int CW    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    cfg_addr,
    input logic [DW-1:0]    cfg_rdata,
    input logic             ais_en,
    input logic             frz_en,
    input logic [CW-1:0]    cnt_eff,
    input logic [NLINK-1:0] bsync_en,
    input logic [NLINK-1:0] hgrp_en,
    input logic [NLINK-1:0] hg_misalign,
    input logic [NLINK-1:0] frm_bit_err,
    input logic [NLINK-1:0] hold,
    input logic             scan_vld,
    input logic [LW-1:0]    ptr_link,
    input logic             sys_valid,
    input logic [LW-1:0]    sys_link,
    input logic [SLW-1:0]   sys_slot,
    input logic [SW-1:0]    sys_sig
);
    localparam logic [DW-1:0] RSVD_MASK = 16'h03FD;

    assert_count_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_eff == '0) |=> !sys_valid);

    assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sys_valid |-> (32'(sys_slot) < NSLOT));

    assert_link_in_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_valid |-> (32'(sys_link) < 32'($past(cnt_eff))));

    assert_error_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_en && frm_bit_err != '0) |=> ((hold & $past(frm_bit_err)) == $past(frm_bit_err)));

    assert_no_freeze_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frz_en |=> (hold == '0));

    assert_ais_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_vld && ais_en && bsync_en[ptr_link] && hgrp_en[ptr_link] && hg_misalign[ptr_link])
        |=> (sys_sig == '1));

    assert_rsvd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == '0) |-> ((cfg_rdata & RSVD_MASK) == '0));
endmodule

bind rsc_unit rsc_unit_chk #(
    .NLINK(NLINK), .NSLOT(NSLOT), .SW(SW), .AW(AW), .DW(DW), .LW(LW), .SLW(SLW), .CW(CW)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
    .ais_en(ais_en), .frz_en(frz_en), .cnt_eff(cnt_eff), .bsync_en(bsync_en),
    .hgrp_en(hgrp_en), .hg_misalign(hg_misalign), .frm_bit_err(frm_bit_err),
    .hold(hold), .scan_vld(scan_vld), .ptr_link(ptr_link), .sys_valid(sys_valid),
    .sys_link(sys_link), .sys_slot(sys_slot), .sys_sig(sys_sig)
);

// File: tb/rsc_unit_tb_top.sv
// Bench for rsc_unit: behavioural reference model updated on each rising edge,
// compared with the outputs on each falling edge, plus directed readback checks.
module rsc_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NLINK = 28;
    localparam int NSLOT = 24;
    localparam int WDOG  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        sig_valid = 1'b0;
    logic [4:0]  sig_link = '0;
    logic [4:0]  sig_slot = '0;
    logic [3:0]  sig_data = '0;
    logic [27:0] frm_bit_err = '0;
    logic [27:0] mf_start = '0;
    logic [27:0] hg_misalign = '0;
    logic        sys_valid;
    logic [4:0]  sys_link;
    logic [4:0]  sys_slot;
    logic [3:0]  sys_sig;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    rsc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .sig_valid(sig_valid),
        .sig_link(sig_link), .sig_slot(sig_slot), .sig_data(sig_data),
        .frm_bit_err(frm_bit_err), .mf_start(mf_start), .hg_misalign(hg_misalign),
        .sys_valid(sys_valid), .sys_link(sys_link), .sys_slot(sys_slot), .sys_sig(sys_sig)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Reference model state
    int    m_mem [NLINK][NSLOT];
    string m_tag [NLINK][NSLOT];
    int    m_fst [NLINK];
    bit    m_bs  [NLINK];
    bit    m_hg  [NLINK];
    bit    m_ais, m_frz;
    int    m_cnt;
    int    p_link, p_slot;
    bit    e_valid;
    int    e_link, e_slot, e_sig;
    string e_vtag, e_stag;

    function automatic int eff_cnt(int c);
        return (c > NLINK) ? NLINK : c;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Model update at each rising edge, from pre-edge state.
    always @(posedge clk) begin
        int ce, l, s;
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < NLINK; i++) begin
                for (int j = 0; j < NSLOT; j++) begin
                    m_mem[i][j] = 0;
                    m_tag[i][j] = "R9";
                end
                m_fst[i] = 0; m_bs[i] = 0; m_hg[i] = 0;
            end
            m_ais = 0; m_frz = 0; m_cnt = 28;
            p_link = 0; p_slot = 0; e_valid = 0;
            e_vtag = "R9"; e_stag = "R9";
        end else begin
            ce = eff_cnt(m_cnt);
            e_valid = (p_link < ce);
            e_vtag = (ce == 0) ? "R1" : "R3";
            if (e_valid) begin
                e_link = p_link;
                e_slot = p_slot;
                if (m_ais && m_bs[p_link] && m_hg[p_link] && hg_misalign[p_link]) begin
                    e_sig = 15; e_stag = "R7";
                end else begin
                    e_sig = m_mem[p_link][p_slot]; e_stag = m_tag[p_link][p_slot];
                end
                if (p_link == ce - 1) begin
                    p_link = 0;
                    p_slot = (p_slot == NSLOT - 1) ? 0 : p_slot + 1;
                end else begin
                    p_link++;
                end
            end else begin
                p_link = 0;
            end
            if (sig_valid) begin
                l = int'(sig_link);
                s = int'(sig_slot);
                if (s < NSLOT && l < NLINK) begin
                    if (l >= ce) m_tag[l][s] = "R4";
                    else if (m_fst[l] != 0 || (m_frz && frm_bit_err[l])) m_tag[l][s] = "R5";
                    else begin
                        m_mem[l][s] = int'(sig_data);
                        m_tag[l][s] = frm_bit_err[l] ? "R6" : "R2";
                    end
                end
            end
            for (int k = 0; k < NLINK; k++) begin
                if (!m_frz) m_fst[k] = 0;
                else if (frm_bit_err[k]) m_fst[k] = 1;
                else if (m_fst[k] == 1 && mf_start[k]) m_fst[k] = 2;
                else if (m_fst[k] == 2 && mf_start[k]) m_fst[k] = 0;
            end
            if (cfg_we) begin
                if (cfg_addr == 6'd0) begin
                    m_ais = cfg_wdata[15];
                    m_cnt = int'(cfg_wdata[14:10]);
                    m_frz = cfg_wdata[1];
                end else if (cfg_addr[5] && int'(cfg_addr[4:0]) < NLINK) begin
                    m_bs[cfg_addr[4:0]] = cfg_wdata[1];
                    m_hg[cfg_addr[4:0]] = cfg_wdata[0];
                end
            end
        end
        if (cyc > WDOG) begin
            check(0, "watchdog", cyc, WDOG);
            report();
        end
    end

    // Compare model and outputs on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sys_valid !== e_valid)
                check(0, e_vtag, int'(sys_valid), int'(e_valid));
            else if (e_valid && (int'(sys_link) != e_link || int'(sys_slot) != e_slot))
                check(0, "R3", int'({sys_link, sys_slot}), (e_link << 5) | e_slot);
            else if (e_valid && int'(sys_sig) != e_sig)
                check(0, e_stag, int'(sys_sig), e_sig);
            else
                check(1, "R3", 0, 0);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(logic [5:0] a, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic read_chk(logic [5:0] a, logic [15:0] exp, string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata === exp, tag, int'(cfg_rdata), int'(exp));
    endtask

    // One stimulus cycle: optional sample with framer strobes.
    task automatic step(bit v, int l, int s, int d, logic [27:0] fe, logic [27:0] mf);
        @(negedge clk);
        sig_valid = v; sig_link = 5'(l); sig_slot = 5'(s); sig_data = 4'(d);
        frm_bit_err = fe; mf_start = mf;
        @(negedge clk);
        sig_valid = 0; frm_bit_err = '0; mf_start = '0;
    endtask

    initial begin
        idle(3);
        // R9 / R1 / R8: reset state
        check(sys_valid === 1'b0, "R9", int'(sys_valid), 0);
        cfg_addr = 6'd0; #1;
        check(cfg_rdata === 16'h7000, "R1", int'(cfg_rdata), 16'h7000);
        cfg_addr = 6'h21; #1;
        check(cfg_rdata === 16'h0000, "R8", int'(cfg_rdata), 0);
        @(negedge clk);
        rst_n = 1;
        idle(2);

        // R2 writes; slot 24 ignored
        step(1, 0, 0, 5, '0, '0);
        step(1, 27, 23, 9, '0, '0);
        step(1, 3, 10, 10, '0, '0);
        step(1, 1, 24, 7, '0, '0);
        idle(700);

        // R4: count 3, link 5 dropped
        cfg_write(6'd0, 16'h0C00);
        read_chk(6'd0, 16'h0C00, "R1");
        step(1, 5, 2, 6, '0, '0);
        idle(100);
        cfg_write(6'd0, 16'h7000);
        idle(700);

        // R5: freeze sequence on link 2; link 1 unaffected
        cfg_write(6'd0, 16'h0C02);
        read_chk(6'd0, 16'h0C02, "R8");
        step(1, 2, 1, 3, 28'h4, '0);
        idle(80);
        step(1, 2, 1, 4, '0, '0);
        step(1, 1, 0, 12, '0, '0);
        idle(80);
        step(0, 0, 0, 0, '0, 28'h4);
        step(1, 2, 1, 5, '0, '0);
        idle(80);
        step(1, 2, 1, 11, '0, 28'h4);
        idle(80);
        step(1, 2, 1, 6, '0, '0);
        idle(80);
        // error coincident with a boundary restarts the sequence
        step(0, 0, 0, 0, 28'h4, 28'h4);
        step(0, 0, 0, 0, '0, 28'h4);
        step(1, 2, 2, 13, '0, '0);
        idle(80);
        step(0, 0, 0, 0, '0, 28'h4);
        step(1, 2, 2, 14, '0, '0);
        idle(80);

        // R6: freeze disabled, error ignored
        cfg_write(6'd0, 16'h0C00);
        step(1, 2, 1, 8, 28'h4, '0);
        idle(80);

        // R7: forcing
        cfg_write(6'h21, 16'h0003);
        cfg_write(6'h20, 16'h0002);
        read_chk(6'h21, 16'h0003, "R7");
        read_chk(6'h3F, 16'h0000, "R8");
        @(negedge clk); hg_misalign = 28'h3;
        cfg_write(6'd0, 16'h8C00);
        read_chk(6'd0, 16'h8C00, "R7");
        idle(80);
        hg_misalign = 28'h1;
        idle(80);
        hg_misalign = 28'h3;
        cfg_write(6'd0, 16'h0C00);
        idle(80);
        hg_misalign = '0;

        // R1: count 0 and count 31
        cfg_write(6'd0, 16'h0000);
        idle(40);
        check(sys_valid === 1'b0, "R1", int'(sys_valid), 0);
        cfg_write(6'd0, 16'h7C00);
        read_chk(6'd0, 16'h7C00, "R1");
        idle(700);

        report();
    end
endmodule